// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block applies one batch of write requests from several processing lanes to a small shared memory. Each lane supplies a valid bit, a target address and a data word. The lane's position in the request vectors is its processor index, and lane 0 is the lowest. When several lanes aim at the same word, a per-batch policy code decides what that word receives. The policy can keep one writer's value, accept the write only when all writers agree, or fold every writer's value into one result. When writers disagree under the agreement policy, the block raises a one-cycle conflict flag for that word.

Each memory word has its own reduction slice, which gathers the lanes that hit that word. The result matches a sort of requests by address and then by lane index, followed by a per-group reduction. A small state machine runs each batch through three states: IDLE, RESOLVE and DONE. IDLE moves to RESOLVE on an accepted start. RESOLVE always moves to DONE, and DONE always moves back to IDLE. Requests and the policy code are latched when start is accepted. The memory write happens on the edge that enters DONE. A combinational read port shows the memory contents at all times.

Top module: `cw_resolver`

## Requirements
- R1: After reset every memory word reads 0, and `busy`, `done` and all `conflict` bits are low.
- R2: `start` is accepted only while `busy` is low. The memory is updated and `done` is high for exactly one cycle, two clock edges after the accepting edge. `busy` stays high from the accepting edge until `done` falls. A `start` raised while `busy` is high is ignored.
- R3: Policy code 0 (priority) stores, for each addressed word, the value of the valid lane with the lowest index aimed at it. A lower index means higher priority.
- R4: Policy code 1 (arbitrary) stores the value of one colliding writer, always the one with the lowest lane index.
- R5: Policy code 2 (common) writes the word only when every valid lane aimed at it carries the same value. Otherwise the word is unchanged and bit `addr` of `conflict` is high in the `done` cycle.
- R6: Policy code 3 (sum) stores the sum modulo 2^DW of all values aimed at the word. The sum starts from zero, not from the old contents.
- R7: Policy codes 4 and 5 store the unsigned minimum and the unsigned maximum of the values aimed at the word.
- R8: Policy codes 6, 7 and 8 store the bitwise AND, OR and XOR of the values aimed at the word.
- R9: Only words targeted by at least one valid lane change. Lanes with valid low have no effect, and policy codes 9 to 15 write nothing.
- R10: `conflict` bits are raised only under policy code 2, and only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to accept a batch |
| mode | input | 4 | Policy code for the batch |
| req_valid | input | NPE | Per-lane request valid, bit i is lane i |
| req_addr | input | NPE*AW | Lane i target address in bits [i*AW +: AW] |
| req_data | input | NPE*DW | Lane i data in bits [i*DW +: DW] |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Memory word at `rd_addr` |
| busy | output | 1 | A batch is in flight |
| done | output | 1 | One-cycle pulse when the memory has been updated |
| conflict | output | 2^AW | Per-word disagreement flags, valid with `done` |

## Verification
Each policy is driven with batches in which all four lanes collide on one word and their values differ. This separates lowest-index selection from the other choices, and it separates a true reduction from keeping a single writer. In the priority runs, lane 0 is left idle or is sent elsewhere, so the bench can tell "lowest valid lane" apart from "lane 0". Common-mode batches include full agreement, one dissenter, and two words resolved together in one batch with only one of them in conflict. The sum runs overflow the data width, and they rewrite an already-written word to show that the old contents are not folded in. Invalid lanes, an unused policy code and a start pulse raised mid-batch each show their lack of effect on the read port.

// File: rtl/cw_pkg.sv
package cw_pkg;

    typedef enum logic [3:0] {
        CW_PRIO   = 4'd0,
        CW_ARB    = 4'd1,
        CW_COMMON = 4'd2,
        CW_SUM    = 4'd3,
        CW_MIN    = 4'd4,
        CW_MAX    = 4'd5,
        CW_AND    = 4'd6,
        CW_OR     = 4'd7,
        CW_XOR    = 4'd8
    } cw_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_DONE    = 2'd2
    } cw_state_e;

endpackage

// File: rtl/cw_addr_reduce.sv
module cw_addr_reduce
    import cw_pkg::*;
#(
    parameter int NPE     = 4,
    parameter int AW      = 3,
    parameter int DW      = 8,
    parameter int MY_ADDR = 0
) (
    input  logic [NPE-1:0]    valid,
    input  logic [NPE*AW-1:0] addr,
    input  logic [NPE*DW-1:0] data,
    input  logic [3:0]        mode,
    output logic              wr_en,
    output logic [DW-1:0]     wr_val,
    output logic              clash
);

    localparam logic [AW-1:0] TAG = AW'(MY_ADDR);

    logic [NPE-1:0] hit;
    logic [DW-1:0]  first_val;
    logic           agree;
    logic [DW-1:0]  acc;
    logic           any_hit;

    // Lanes aimed at this word
    generate
        for (genvar g = 0; g < NPE; g++) begin : g_hit
            assign hit[g] = valid[g] && (addr[g*AW +: AW] == TAG);
        end
    endgenerate

    assign any_hit = |hit;

    function automatic logic [DW-1:0] identity(input logic [3:0] m);
        case (m)
            CW_AND, CW_MIN: identity = '1;
            default:        identity = '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] fold(input logic [3:0] m,
                                           input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
        case (m)
            CW_SUM:  fold = a + b;
            CW_MIN:  fold = (b < a) ? b : a;
            CW_MAX:  fold = (b > a) ? b : a;
            CW_AND:  fold = a & b;
            CW_OR:   fold = a | b;
            CW_XOR:  fold = a ^ b;
            default: fold = a;
        endcase
    endfunction

    // Lowest-index writer: scan from the top so the lowest hit wins
    always_comb begin
        first_val = '0;
        for (int i = NPE - 1; i >= 0; i--) begin
            if (hit[i]) first_val = data[i*DW +: DW];
        end
    end

    // Agreement among every writer of this word
    always_comb begin
        agree = 1'b1;
        for (int i = 0; i < NPE; i++) begin
            if (hit[i] && (data[i*DW +: DW] != first_val)) agree = 1'b0;
        end
    end

    // Combining accumulator, seeded with the operator identity
    always_comb begin
        acc = identity(mode);
        for (int i = 0; i < NPE; i++) begin
            if (hit[i]) acc = fold(mode, acc, data[i*DW +: DW]);
        end
    end

    always_comb begin
        wr_en  = 1'b0;
        wr_val = first_val;
        clash  = 1'b0;
        case (mode)
            CW_PRIO, CW_ARB: begin
                wr_en = any_hit;
            end
            CW_COMMON: begin
                wr_en = any_hit && agree;
                clash = any_hit && !agree;
            end
            CW_SUM, CW_MIN, CW_MAX, CW_AND, CW_OR, CW_XOR: begin
                wr_en  = any_hit;
                wr_val = acc;
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cw_ctrl.sv
module cw_ctrl
    import cw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic capture,
    output logic commit
);

    cw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        capture = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE:    capture = start;
            ST_RESOLVE: begin busy = 1'b1; commit = 1'b1; end
            ST_DONE:    begin busy = 1'b1; done = 1'b1; end
            default:    busy = 1'b0;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
    AST_CAPTURE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) capture |-> !busy); // R2

endmodule

// File: rtl/cw_store.sv
module cw_store #(
    parameter int AW    = 3,
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [DEPTH-1:0]    wr_en,
    input  logic [DEPTH*DW-1:0] wr_val,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);

    logic [DEPTH-1:0][DW-1:0] mem_q;

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n)                  mem_q[w] <= '0;
                else if (commit && wr_en[w]) mem_q[w] <= wr_val[w*DW +: DW];
            end
        end
    endgenerate

    assign rd_data = mem_q[rd_addr];

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !commit |=> $stable(mem_q)); // R9

endmodule

// File: rtl/cw_resolver.sv
module cw_resolver
    import cw_pkg::*;
#(
    parameter int NPE = 4,
    parameter int AW  = 3,
    parameter int DW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [3:0]          mode,
    input  logic [NPE-1:0]      req_valid,
    input  logic [NPE*AW-1:0]   req_addr,
    input  logic [NPE*DW-1:0]   req_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    output logic                busy,
    output logic                done,
    output logic [(1<<AW)-1:0]  conflict
);

    localparam int DEPTH = 1 << AW;

    logic capture, commit;

    logic [NPE-1:0]      valid_q;
    logic [NPE*AW-1:0]   addr_q;
    logic [NPE*DW-1:0]   data_q;
    logic [3:0]          mode_q;

    logic [DEPTH-1:0]    wen;
    logic [DEPTH*DW-1:0] wval;
    logic [DEPTH-1:0]    clash;
    logic [DEPTH-1:0]    conflict_q;

    // Batch latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            mode_q  <= '0;
        end else if (capture) begin
            valid_q <= req_valid;
            addr_q  <= req_addr;
            data_q  <= req_data;
            mode_q  <= mode;
        end
    end

    cw_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (done),
        .capture (capture),
        .commit  (commit)
    );

    generate
        for (genvar a = 0; a < DEPTH; a++) begin : g_red
            cw_addr_reduce #(
                .NPE     (NPE),
                .AW      (AW),
                .DW      (DW),
                .MY_ADDR (a)
            ) u_red (
                .valid  (valid_q),
                .addr   (addr_q),
                .data   (data_q),
                .mode   (mode_q),
                .wr_en  (wen[a]),
                .wr_val (wval[a*DW +: DW]),
                .clash  (clash[a])
            );
        end
    endgenerate

    cw_store #(
        .AW    (AW),
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wr_en   (wen),
        .wr_val  (wval),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Conflict flags live for the single DONE cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      conflict_q <= '0;
        else if (commit) conflict_q <= clash;
        else             conflict_q <= '0;
    end

    assign conflict = conflict_q;

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> ##1 done); // R2
    AST_CONFLICT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) (|conflict_q) |-> done); // R10
    AST_CONFLICT_COMMON_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (|conflict_q) |-> (mode_q == CW_COMMON)); // R10

endmodule

// File: tb/tb_cw_resolver.sv
module tb_cw_resolver;

    localparam int NPE = 4;
    localparam int AW  = 3;
    localparam int DW  = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC = 14;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [3:0]          mode = '0;
    logic [NPE-1:0]      req_valid = '0;
    logic [NPE*AW-1:0]   req_addr = '0;
    logic [NPE*DW-1:0]   req_data = '0;
    logic [AW-1:0]       rd_addr = '0;
    logic [DW-1:0]       rd_data;
    logic                busy, done;
    logic [DEPTH-1:0]    conflict;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    cw_resolver #(.NPE(NPE), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .conflict(conflict)
    );

    // {mode, valid, addr(lane3..0 octal), data(lane3..0), check addr, expected word, expected conflict}
    localparam logic [70:0] VECS [NVEC] = '{
        {4'd0, 4'b1110, 12'o2222, 32'h44332211, 3'd2, 8'h22, 8'h00},
        {4'd1, 4'b1111, 12'o3333, 32'h80706050, 3'd3, 8'h50, 8'h00},
        {4'd2, 4'b0101, 12'o4444, 32'h775A995A, 3'd4, 8'h5A, 8'h00},
        {4'd2, 4'b1111, 12'o4444, 32'h5A5B5A5A, 3'd4, 8'h5A, 8'h10},
        {4'd3, 4'b1111, 12'o5555, 32'hF0302010, 3'd5, 8'h50, 8'h00},
        {4'd3, 4'b0001, 12'o5555, 32'h00000003, 3'd5, 8'h03, 8'h00},
        {4'd4, 4'b1111, 12'o6666, 32'h20900840, 3'd6, 8'h08, 8'h00},
        {4'd5, 4'b1111, 12'o6666, 32'h20900840, 3'd6, 8'h90, 8'h00},
        {4'd6, 4'b1111, 12'o7777, 32'hB4FF3CF0, 3'd7, 8'h30, 8'h00},
        {4'd7, 4'b1111, 12'o0000, 32'h80040201, 3'd0, 8'h87, 8'h00},
        {4'd8, 4'b1111, 12'o7777, 32'h10010FFF, 3'd7, 8'hE1, 8'h00},
        {4'd0, 4'b0111, 12'o3121, 32'hDDC3B2A1, 3'd1, 8'hA1, 8'h00},
        {4'd2, 4'b1111, 12'o3322, 32'h02016666, 3'd2, 8'h66, 8'h08},
        {4'd9, 4'b1111, 12'o0000, 32'h01010101, 3'd0, 8'h87, 8'h00}
    };

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0:       tag_of = "R3";
            4'd1:       tag_of = "R4";
            4'd2:       tag_of = "R5";
            4'd3:       tag_of = "R6";
            4'd4, 4'd5: tag_of = "R7";
            4'd6, 4'd7, 4'd8: tag_of = "R8";
            default:    tag_of = "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_word(input logic [AW-1:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic run_batch(input logic [3:0] m, input logic [3:0] v,
                             input logic [11:0] a, input logic [31:0] d,
                             output logic [DEPTH-1:0] conf_seen);
        @(negedge clk);
        mode = m; req_valid = v; req_addr = a; req_data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy during resolve", {15'd0, busy}, 16'd1);
        check("R2 done not early", {15'd0, done}, 16'd0);
        @(negedge clk);
        check("R2 done after two edges", {15'd0, done}, 16'd1);
        conf_seen = conflict;
        @(negedge clk);
        check("R2 done one cycle", {15'd0, done}, 16'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 50000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w;
        logic [DEPTH-1:0] cf;
        int dones;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R1 done", {15'd0, done}, 16'd0);
        check("R1 conflict", {8'd0, conflict}, 16'd0);
        for (int a = 0; a < DEPTH; a++) begin
            read_word(AW'(a), w);
            check("R1 memory zero", {8'd0, w}, 16'd0);
        end

        // Vector table walk
        for (int k = 0; k < NVEC; k++) begin
            run_batch(VECS[k][70:67], VECS[k][66:63], VECS[k][62:51], VECS[k][50:19], cf);
            check("R10 conflict flags (R5)", {8'd0, cf}, {8'd0, VECS[k][7:0]});
            read_word(VECS[k][18:16], w);
            check(tag_of(VECS[k][70:67]), {8'd0, w}, {8'd0, VECS[k][15:8]});
        end

        // R9 invalid lane and conflicting common batch left word 3 alone
        read_word(3'd3, w);
        check("R9 word 3 untouched", {8'd0, w}, 16'h0050);
        read_word(3'd1, w);
        check("R3 mixed-address lowest lane", {8'd0, w}, 16'h00A1);

        // R2 start raised while busy is ignored
        @(negedge clk);
        mode = 4'd0; req_valid = 4'b0001; req_addr = 12'o0006; req_data = 32'h0000003C; start = 1'b1;
        @(negedge clk);
        req_addr = 12'o0003; req_data = 32'h000000EE; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 done for first batch", {15'd0, done}, 16'd1);
        dones = 0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (done) dones++;
        end
        check("R2 no second done", 16'(dones), 16'd0);
        check("R2 idle afterwards", {15'd0, busy}, 16'd0);
        read_word(3'd3, w);
        check("R2 busy start ignored", {8'd0, w}, 16'h0050);
        read_word(3'd6, w);
        check("R3 accepted batch written", {8'd0, w}, 16'h003C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule